// File: doc/BRIEF.md
# Single-Channel Byte DMA Engine with Burst and Cycle-Steal Modes

This block moves a block of bytes from an I/O device port into system memory over a shared bus. The processor does not take part in the transfer. Software sets a start address and a byte count through a small configuration port. It then writes a control word that picks the bus mode and starts the engine. From then on the engine takes bytes from the device, keeps each one in an internal byte register, and writes it to memory. To get the bus, it uses a request/grant handshake with the processor.

In burst mode, the engine keeps its request high from the first grant until the last byte is written. It writes one byte per cycle while the device has data ready. In cycle-steal mode, it drops its request after every byte, so the processor gets the bus between bytes. It also keeps the request low while it waits for the device. When the block is complete, a sticky completion flag is raised for the processor. That flag stays high until the next write to the control word.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_req, bus_we, dev_ack and done_irq are all low.
- R2: Configuration writes select a field with cfg_sel: 0 is the start address, 1 is the byte count and 2 is the control word. In the control word, bit 0 starts a transfer and bit 1 picks the mode (1 = cycle-steal, 0 = burst). While a transfer is active, writes to the address, count and mode, and any start, have no effect.
- R3: A byte is taken from the device (dev_ack high) only in a cycle where dev_valid is high. Memory receives the taken bytes in the order the device presented them.
- R4: The first memory write goes to the start address, and each later write goes to the previous address plus one. The count drops by one per write, and exactly the configured count of writes is made.
- R5: bus_we is high only in cycles where bus_gnt is high. bus_addr and bus_wdata are zero whenever bus_gnt is low. A write occupies one cycle.
- R6: In burst mode, once the first byte has been written, bus_req stays high until the last byte is written, including while the device has no data. While the grant holds and the device stays ready, the writes fall in consecutive cycles.
- R7: In cycle-steal mode, bus_req is low in the cycle after every write. It stays low while the engine waits for device data. This gives one request release per byte.
- R8: done_irq rises in the cycle after the final write. It stays high until the next control-word write, which clears it.
- R9: A start with a byte count of zero sets done_irq in the next cycle and never raises bus_req.
- R10: bus_req and done_irq are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Field select: 0 address, 1 count, 2 control |
| cfg_wdata | input | CFG_W | Configuration write data |
| dev_valid | input | 1 | Device has a byte ready |
| dev_data | input | BYTE_W | Byte offered by the device |
| dev_ack | output | 1 | Byte taken from the device this cycle |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| bus_we | output | 1 | Memory write strobe |
| bus_addr | output | ADDR_W | Memory write address |
| bus_wdata | output | BYTE_W | Memory write data |
| done_irq | output | 1 | Sticky completion interrupt |

## Verification
Some properties are checked by assertions on every cycle. These cover the rule that the bus is driven only under grant, the request drop after each write in cycle-steal mode, and the request hold after each mid-block write in burst mode. They also cover the address and count stepping per write, the completion flag rising after the last byte and staying set, and the zero-count start. Other behaviour only shows up across whole scenarios, so the bench's transfers demonstrate it. This includes the byte order and addresses seen in memory, back-to-back timing in burst mode, and the number of request releases per block in each mode. It also includes the request held through a device stall, the wait on a withheld grant, and the lockout of reconfiguration while a transfer is running.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    localparam int SEL_W = 2;

    localparam logic [SEL_W-1:0] SEL_ADDR  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_COUNT = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CTRL  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_HAVE  = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic steal;
        logic go;
    } ctrl_cmd_t;

    function automatic ctrl_cmd_t decode_ctrl(input logic [1:0] bits);
        ctrl_cmd_t c;
        c.go    = bits[0];
        c.steal = bits[1];
        return c;
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int CFG_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 busy,
    input  logic                 step,
    input  logic                 load_byte,
    input  logic [BYTE_W-1:0]    dev_data,
    output logic [ADDR_W-1:0]    addr_q,
    output logic [BYTE_W-1:0]    byte_q,
    output logic                 steal_q,
    output logic                 cnt_zero,
    output logic                 cnt_last
);

    logic [CNT_W-1:0] cnt_q;
    logic             cfg_ok;
    ctrl_cmd_t        cmd;

    assign cfg_ok   = cfg_wr && !busy;
    assign cmd      = decode_ctrl(cfg_wdata[1:0]);
    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            byte_q  <= '0;
            steal_q <= 1'b0;
        end else begin
            if (cfg_ok && cfg_sel == SEL_ADDR)
                addr_q <= cfg_wdata[ADDR_W-1:0];
            else if (step)
                addr_q <= addr_q + 1'b1;

            if (cfg_ok && cfg_sel == SEL_COUNT)
                cnt_q <= cfg_wdata[CNT_W-1:0];
            else if (step)
                cnt_q <= cnt_q - 1'b1;

            if (cfg_ok && cfg_sel == SEL_CTRL)
                steal_q <= cmd.steal;

            if (load_byte)
                byte_q <= dev_data;
        end
    end

    // R4: address advances by one per write
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        step |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

    // R4: remaining count drops by one per write
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        step |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

    // R2: configuration is frozen while a transfer runs
    a_r2_frozen_mode: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(steal_q));

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic go_bit,
    input  logic cnt_zero,
    input  logic cnt_last,
    input  logic steal,
    input  logic dev_valid,
    input  logic bus_gnt,
    output logic busy,
    output logic load_byte,
    output logic step,
    output logic bus_req,
    output logic done
);

    xfer_state_e st_q, st_d;
    logic        hold_q, hold_d;
    logic        done_q, done_d;
    logic        chain;

    assign busy    = (st_q != ST_IDLE);
    assign step    = (st_q == ST_HAVE) && bus_gnt;
    assign bus_req = (st_q == ST_HAVE) || ((st_q == ST_FETCH) && hold_q);
    assign chain   = step && !steal && !cnt_last && dev_valid;
    assign load_byte = ((st_q == ST_FETCH) && dev_valid) || chain;
    assign done    = done_q;

    always_comb begin
        st_d   = st_q;
        hold_d = hold_q;
        done_d = done_q;
        case (st_q)
            ST_IDLE: begin
                if (ctrl_wr) begin
                    done_d = 1'b0;
                    if (go_bit) begin
                        if (cnt_zero) done_d = 1'b1;
                        else          st_d   = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (dev_valid) st_d = ST_HAVE;
            end
            ST_HAVE: begin
                if (step) begin
                    if (cnt_last) begin
                        st_d   = ST_IDLE;
                        hold_d = 1'b0;
                        done_d = 1'b1;
                    end else begin
                        hold_d = !steal;
                        st_d   = chain ? ST_HAVE : ST_FETCH;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            hold_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            hold_q <= hold_d;
            done_q <= done_d;
        end
    end

    // R7: request released right after each write in cycle-steal mode
    a_r7_steal_release: assert property (@(posedge clk) disable iff (rst)
        (step && steal) |=> !bus_req);

    // R6: request kept after a mid-block write in burst mode
    a_r6_burst_keep: assert property (@(posedge clk) disable iff (rst)
        (step && !steal && !cnt_last) |=> bus_req);

    // R8: completion follows the final write
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_last) |=> done);

    // R8: completion is sticky until a control write
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && !ctrl_wr) |=> done);

    // R9: zero-length start completes without a request
    a_r9_zero_len: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctrl_wr && go_bit && cnt_zero) |=> (done && !bus_req));

    // R3: a byte is only taken when the device offers one
    a_r3_take_valid: assert property (@(posedge clk) disable iff (rst)
        load_byte |-> dev_valid);

    // R10: request and completion exclusive
    a_r10_req_not_done: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !done);

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int CFG_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 dev_valid,
    input  logic [BYTE_W-1:0]    dev_data,
    output logic                 dev_ack,
    output logic                 bus_req,
    input  logic                 bus_gnt,
    output logic                 bus_we,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [BYTE_W-1:0]    bus_wdata,
    output logic                 done_irq
);

    logic              busy, step, load_byte, steal_q, cnt_zero, cnt_last;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] byte_q;
    logic              ctrl_wr;
    ctrl_cmd_t         cmd;

    assign ctrl_wr = cfg_wr && (cfg_sel == SEL_CTRL);
    assign cmd     = decode_ctrl(cfg_wdata[1:0]);

    dma_chan_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .BYTE_W (BYTE_W),
        .CFG_W  (CFG_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .busy      (busy),
        .step      (step),
        .load_byte (load_byte),
        .dev_data  (dev_data),
        .addr_q    (addr_q),
        .byte_q    (byte_q),
        .steal_q   (steal_q),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last)
    );

    dma_xfer_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .go_bit    (cmd.go),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .steal     (steal_q),
        .dev_valid (dev_valid),
        .bus_gnt   (bus_gnt),
        .busy      (busy),
        .load_byte (load_byte),
        .step      (step),
        .bus_req   (bus_req),
        .done      (done_irq)
    );

    assign dev_ack   = load_byte;
    assign bus_we    = step;
    assign bus_addr  = step ? addr_q : '0;
    assign bus_wdata = step ? byte_q : '0;

    // R5: nothing driven onto the bus without a grant
    a_r5_quiet_without_gnt: assert property (@(posedge clk) disable iff (rst)
        !bus_gnt |-> (!bus_we && bus_addr == '0 && bus_wdata == '0));

    // R5: a write only happens while requesting
    a_r5_write_under_req: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> bus_req);

endmodule

// File: tb/dma_xfer_ctrl_test.sv
module dma_xfer_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int CFG_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wr = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic              dev_valid = 1'b0;
    logic [BYTE_W-1:0] dev_data = '0;
    logic              dev_ack;
    logic              bus_req;
    logic              bus_gnt = 1'b0;
    logic              bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [BYTE_W-1:0] bus_wdata;
    logic              done_irq;

    dma_xfer_ctrl uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dev_valid(dev_valid), .dev_data(dev_data),
        .dev_ack(dev_ack), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .done_irq(done_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [BYTE_W-1:0]        dev_fifo[$];
    logic [ADDR_W+BYTE_W-1:0] exp_q[$];
    bit dev_pause = 0;
    bit gnt_block = 0;
    bit ack_seen = 0, req_seen = 0, req_prev = 0;
    int cyc = 0, first_we = -1, last_we = -1, we_count = 0;
    int req_falls = 0, req_rises = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops scoreboard on every memory write
    always @(negedge clk) begin
        cyc++;
        ack_seen = dev_ack;
        req_seen = bus_req;
        if (!rst) begin
            if (!bus_req && req_prev) req_falls++;
            if (bus_req && !req_prev) req_rises++;
            req_prev = bus_req;
            if (bus_we) begin
                we_count++;
                if (first_we < 0) first_we = cyc;
                last_we = cyc;
                if (exp_q.size() == 0) begin
                    check(0, "R4", "unexpected write", {bus_addr, bus_wdata}, 0);
                end else begin
                    logic [ADDR_W+BYTE_W-1:0] e;
                    e = exp_q.pop_front();
                    check({bus_addr, bus_wdata} == e, "R3", "addr/data of write",
                          {bus_addr, bus_wdata}, e);
                end
            end
            if (!bus_gnt && (bus_we || bus_addr != 0 || bus_wdata != 0))
                check(0, "R5", "bus driven without grant", {bus_we, bus_addr}, 0);
            if (dev_ack && !dev_valid)
                check(0, "R3", "ack without valid", dev_ack, 0);
        end
    end

    // device and arbiter models, driven just after the edge
    always @(posedge clk) begin
        #1;
        if (ack_seen && dev_fifo.size() > 0) void'(dev_fifo.pop_front());
        dev_valid = (dev_fifo.size() > 0) && !dev_pause;
        dev_data  = (dev_fifo.size() > 0) ? dev_fifo[0] : '0;
        bus_gnt   = req_seen && !gnt_block && !rst;
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [CFG_W-1:0] d);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic expect_block(input int base, input int n, input int seed, input int dev_n);
        for (int i = 0; i < n; i++) begin
            logic [BYTE_W-1:0] b;
            b = BYTE_W'(seed + i * 37);
            exp_q.push_back({ADDR_W'(base + i), b});
            if (i < dev_n) dev_fifo.push_back(b);
        end
    endtask

    task automatic clear_stats();
        first_we = -1; last_we = -1; we_count = 0; req_falls = 0; req_rises = 0;
    endtask

    task automatic wait_done(input string req);
        int k;
        k = 0;
        while (!done_irq && k < 500) begin
            @(negedge clk);
            k++;
        end
        check(done_irq == 1'b1, req, "done after block", done_irq, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R1", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs after reset
        check(bus_req == 0 && bus_we == 0, "R1", "bus idle after reset", {bus_req, bus_we}, 0);
        check(done_irq == 0 && dev_ack == 0, "R1", "done/ack low after reset", {done_irq, dev_ack}, 0);

        // burst block of 5
        clear_stats();
        expect_block(16'h0100, 5, 8'h11, 5);
        cfg_write(2'd0, 16'h0100);
        cfg_write(2'd1, 16'd5);
        cfg_write(2'd2, 16'h0001);
        wait_done("R8");
        check(we_count == 5, "R4", "burst write count", we_count, 5);
        check(last_we - first_we == 4, "R6", "burst writes back to back", last_we - first_we, 4);
        check(req_falls == 1, "R6", "burst single release", req_falls, 1);
        check(exp_q.size() == 0, "R3", "burst scoreboard drained", exp_q.size(), 0);
        check(bus_req == 0, "R10", "request low when done", bus_req, 0);

        // R8 sticky then cleared by control write
        repeat (5) @(negedge clk);
        check(done_irq == 1, "R8", "done stays set", done_irq, 1);
        cfg_write(2'd2, 16'h0000);
        @(negedge clk);
        check(done_irq == 0, "R8", "done cleared by control write", done_irq, 0);

        // cycle-steal block of 4
        clear_stats();
        expect_block(16'h2000, 4, 8'h5a, 4);
        cfg_write(2'd0, 16'h2000);
        cfg_write(2'd1, 16'd4);
        cfg_write(2'd2, 16'h0003);
        wait_done("R8");
        check(req_falls == 4, "R7", "one release per byte", req_falls, 4);
        check(last_we - first_we >= 6, "R7", "writes spaced out", last_we - first_we, 6);
        check(we_count == 4 && exp_q.size() == 0, "R4", "steal block complete", we_count, 4);

        // cycle-steal with device stalled: no request while waiting
        clear_stats();
        dev_pause = 1;
        expect_block(16'h2100, 2, 8'h80, 2);
        cfg_write(2'd0, 16'h2100);
        cfg_write(2'd1, 16'd2);
        cfg_write(2'd2, 16'h0003);
        repeat (10) @(negedge clk);
        check(bus_req == 0 && we_count == 0, "R7", "no request while device idle", {bus_req, we_count[7:0]}, 0);
        check(dev_ack == 0, "R3", "no take without valid", dev_ack, 0);
        dev_pause = 0;
        wait_done("R8");
        check(we_count == 2 && exp_q.size() == 0, "R3", "stalled steal completes", we_count, 2);

        // burst with device running dry mid-block: request held
        clear_stats();
        expect_block(16'h3000, 4, 8'hc3, 2);
        cfg_write(2'd0, 16'h3000);
        cfg_write(2'd1, 16'd4);
        cfg_write(2'd2, 16'h0001);
        while (we_count < 2) @(negedge clk);
        repeat (4) @(negedge clk);
        check(bus_req == 1 && done_irq == 0, "R6", "request held through stall", {bus_req, done_irq}, 2);
        dev_fifo.push_back(exp_q[0][BYTE_W-1:0]);
        dev_fifo.push_back(exp_q[1][BYTE_W-1:0]);
        wait_done("R8");
        check(req_falls == 1 && exp_q.size() == 0, "R6", "burst with stall one release", req_falls, 1);

        // grant withheld: no write until granted
        clear_stats();
        gnt_block = 1;
        expect_block(16'h4000, 2, 8'h07, 2);
        cfg_write(2'd0, 16'h4000);
        cfg_write(2'd1, 16'd2);
        cfg_write(2'd2, 16'h0001);
        repeat (8) @(negedge clk);
        check(we_count == 0 && bus_req == 1, "R5", "waits for grant", {we_count[7:0], bus_req}, 1);
        gnt_block = 0;
        wait_done("R8");
        check(exp_q.size() == 0, "R5", "write after grant", exp_q.size(), 0);

        // zero-length start
        clear_stats();
        cfg_write(2'd1, 16'd0);
        cfg_write(2'd2, 16'h0001);
        @(negedge clk);
        check(done_irq == 1, "R9", "zero length done", done_irq, 1);
        repeat (4) @(negedge clk);
        check(req_rises == 0 && we_count == 0, "R9", "zero length no request", req_rises, 0);

        // reconfiguration while busy ignored
        clear_stats();
        dev_pause = 1;
        expect_block(16'h0300, 3, 8'h21, 3);
        cfg_write(2'd0, 16'h0300);
        cfg_write(2'd1, 16'd3);
        cfg_write(2'd2, 16'h0003);
        cfg_write(2'd0, 16'h7777);
        cfg_write(2'd1, 16'd9);
        cfg_write(2'd2, 16'h0001);
        dev_pause = 0;
        wait_done("R8");
        check(we_count == 3 && exp_q.size() == 0, "R2", "busy writes ignored", we_count, 3);
        check(req_falls == 3, "R2", "mode kept while busy", req_falls, 3);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule